// File: doc/BRIEF.md
# Folded-Instruction Profiling Counter

This block keeps a small wrapping count of instructions that the core retired without spending a cycle of their own. Each clock the core reports how many instructions completed in that cycle. When two or more completed, all but one of them counted as free. The counter therefore advances by the reported number minus one. When the number is zero or one, it holds.

Software reaches the counter through a simple 32-bit register port and can read or overwrite it. An event-enable input controls a one-cycle overflow pulse. The pulse marks each cycle in which the count carried past its top value. A rising edge on the enable restarts the count from zero. A build parameter removes the counter altogether. In that build the register reads as zero, writes are dropped and no event is ever raised.

Top module: `fold_prof_counter`

## Requirements
- R1: After synchronous reset the count reads 0x00 and the overflow event output is low.
- R2: The count sits in bits 7:0 of the 32-bit read word, and bits 31:8 always read as zero.
- R3: In a cycle with no clear and no write, a retired value n on the 3-bit input (0 to 7) with n >= 2 adds n-1 to the count modulo 256. With n of 0 or 1 the count is unchanged. The new value is visible one clock later.
- R4: The overflow event goes high for exactly one cycle, in the clock after an addition that carries out of bit 7, including when the wrapped result is not zero.
- R5: While the event enable is 0, no overflow event is emitted, but counting and wrapping continue.
- R6: A 0-to-1 change of the event enable, sampled against its value in the previous clock, clears the count to zero on the next clock. It overrides a write and an increment in the same cycle and produces no event. The enable is taken as 0 at reset.
- R7: A write loads bits 7:0 of the write data into the count on the next clock. It overrides the increment of that cycle and raises no overflow event.
- R8: With the counter disabled by its build parameter, the read word is always zero, writes have no effect and the overflow event stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retired_i | input | 3 | Instructions completed in this cycle |
| evt_en_i | input | 1 | Overflow event enable; its rising edge clears the count |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data; bits 7:0 are used |
| rd_data_o | output | 32 | Register read data |
| ovf_evt_o | output | 1 | One-cycle overflow event pulse |

## Verification
The bench preloads every one of the 256 count values by write and applies every retired value from 0 to 7 to each. This catches a design that adds n instead of n-1, counts single-instruction cycles, or flags overflow only when the count wraps exactly to zero. It also checks the overlaps. An enable rise together with a write must still end at zero; a design with the priority reversed would keep the written value. A write together with a large increment must keep the written value and give no pulse. Near-wrap additions with the enable low must wrap silently, where an ungated design would pulse. A second instance, built with the counter disabled, is checked on every cycle for a zero read and a silent event line.

// File: rtl/fold_prof_pkg.sv
package fold_prof_pkg;

  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_CLEAR = 2'd1,
    UPD_LOAD  = 2'd2,
    UPD_ADD   = 2'd3
  } upd_e;

endpackage

// File: rtl/fold_inc_calc.sv
module fold_inc_calc #(
  parameter int RET_W = 3,
  parameter int CNT_W = 8
) (
  input  logic [RET_W-1:0] retired_i,
  output logic [CNT_W-1:0] addend_o
);

  // One instruction per cycle is the normal rate; only the extra ones count.
  always_comb begin
    if (retired_i >= RET_W'(2)) addend_o = CNT_W'(retired_i) - CNT_W'(1);
    else                        addend_o = '0;
  end

endmodule

// File: rtl/fold_evt_ctl.sv
module fold_evt_ctl (
  input  logic clk,
  input  logic rst,
  input  logic evt_en_i,
  output logic rise_o
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= evt_en_i;
  end

  assign rise_o = evt_en_i & ~en_q;

endmodule

// File: rtl/fold_cnt_core.sv
module fold_cnt_core
  import fold_prof_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  upd_e             upd_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic [CNT_W-1:0] addend_i,
  input  logic             evt_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  logic [CNT_W:0] sum;

  always_comb sum = {1'b0, cnt_o} + {1'b0, addend_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      unique case (upd_i)
        UPD_CLEAR: cnt_o <= '0;
        UPD_LOAD:  cnt_o <= load_i;
        UPD_ADD: begin
          cnt_o <= sum[CNT_W-1:0];
          ovf_o <= sum[CNT_W] & evt_en_i;
        end
        default:   cnt_o <= cnt_o;
      endcase
    end
  end

  // R4: an addend below 2^(CNT_W-1) cannot wrap twice in consecutive cycles
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> !ovf_o);

  // R7: a load produces no event
  a_r7_load_quiet: assert property (@(posedge clk) disable iff (rst)
    (upd_i == UPD_LOAD) |=> !ovf_o);

endmodule

// File: rtl/fold_prof_counter.sv
module fold_prof_counter
  import fold_prof_pkg::*;
#(
  parameter int RET_W = 3,
  parameter int CNT_W = 8,
  parameter int REG_W = 32,
  parameter bit IMPL  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       retired_i,
  input  logic             evt_en_i,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [31:0]      rd_data_o,
  output logic             ovf_evt_o
);

  localparam int PAD_W = REG_W - CNT_W;

  logic unused_hi;
  assign unused_hi = ^wr_data_i[REG_W-1:CNT_W];

  generate
    if (IMPL) begin : g_impl
      logic [CNT_W-1:0] addend;
      logic [CNT_W-1:0] cnt;
      logic             rise;
      upd_e             upd;

      fold_inc_calc #(.RET_W(RET_W), .CNT_W(CNT_W)) inc_i (
        .retired_i (retired_i),
        .addend_o  (addend)
      );

      fold_evt_ctl evt_i (
        .clk      (clk),
        .rst      (rst),
        .evt_en_i (evt_en_i),
        .rise_o   (rise)
      );

      // Priority: enable-rise clear, then software write, then increment.
      always_comb begin
        if (rise)              upd = UPD_CLEAR;
        else if (wr_en_i)      upd = UPD_LOAD;
        else if (addend != '0) upd = UPD_ADD;
        else                   upd = UPD_HOLD;
      end

      fold_cnt_core #(.CNT_W(CNT_W)) core_i (
        .clk      (clk),
        .rst      (rst),
        .upd_i    (upd),
        .load_i   (wr_data_i[CNT_W-1:0]),
        .addend_i (addend),
        .evt_en_i (evt_en_i),
        .cnt_o    (cnt),
        .ovf_o    (ovf_evt_o)
      );

      assign rd_data_o = {{PAD_W{1'b0}}, cnt};

      // R6: enable rise clears the count whatever else happens
      a_r6_rise_clears: assert property (@(posedge clk) disable iff (rst)
        rise |=> (cnt == '0) && !ovf_evt_o);

      // R7: a write loads the low byte
      a_r7_write_loads: assert property (@(posedge clk) disable iff (rst)
        (!rise && wr_en_i) |=> cnt == $past(wr_data_i[CNT_W-1:0]));

      // R3: zero or one retired instruction leaves the count alone
      a_r3_hold_low: assert property (@(posedge clk) disable iff (rst)
        (!rise && !wr_en_i && retired_i < 3'd2) |=> $stable(cnt));

      // R5: no event follows a cycle with the enable low
      a_r5_gated: assert property (@(posedge clk) disable iff (rst)
        !evt_en_i |=> !ovf_evt_o);

      // R2: upper bits are zero
      a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[REG_W-1:CNT_W] == '0);
    end else begin : g_absent
      logic unused_in;
      assign unused_in = ^{retired_i, evt_en_i, wr_en_i, wr_data_i[CNT_W-1:0]};
      assign rd_data_o = '0;
      assign ovf_evt_o = 1'b0;

      // R8: disabled build stays silent
      a_r8_silent: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o == '0) && !ovf_evt_o);
    end
  endgenerate

endmodule

// File: tb/fold_prof_counter_tb.sv
module fold_prof_counter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  retired = '0;
  logic        evt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_off;
  logic        ovf, ovf_off;

  int compared = 0;
  int mismatched = 0;

  int unsigned m_cnt = 0;
  bit          m_en_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fold_prof_counter dut_i (
    .clk (clk), .rst (rst), .retired_i (retired), .evt_en_i (evt_en),
    .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_data_o (rd_data), .ovf_evt_o (ovf)
  );

  fold_prof_counter #(.IMPL(1'b0)) dut_off_i (
    .clk (clk), .rst (rst), .retired_i (retired), .evt_en_i (evt_en),
    .wr_en_i (wr_en), .wr_data_i (wr_data), .rd_data_o (rd_off), .ovf_evt_o (ovf_off)
  );

  task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, predict, then compare at the next falling edge.
  task automatic step(input int ret, input bit en, input bit we, input logic [31:0] wd,
                      input string tag_cnt, input string tag_ovf);
    bit          rise;
    int unsigned add, sum;
    bit          m_ovf;
    retired = 3'(ret);
    evt_en  = en;
    wr_en   = we;
    wr_data = wd;
    rise  = en && !m_en_prev;
    m_ovf = 1'b0;
    if (rise) m_cnt = 0;
    else if (we) m_cnt = wd & 32'hFF;
    else begin
      add   = (ret >= 2) ? ret - 1 : 0;
      sum   = m_cnt + add;
      m_ovf = (sum > 255) && en;
      m_cnt = sum & 32'hFF;
    end
    m_en_prev = en;
    @(posedge clk);
    @(negedge clk);
    chk32(rd_data, 32'(m_cnt), tag_cnt);
    chk32({31'b0, ovf}, {31'b0, m_ovf}, tag_ovf);
    chk32(rd_off, 32'h0, "R8 read");
    chk32({31'b0, ovf_off}, 32'h0, "R8 event");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk32(rd_data, 32'h0, "R1 count");
    chk32({31'b0, ovf}, 32'h0, "R1 event");

    // R2: only bits 7:0 are kept, upper bits read zero
    step(0, 1'b0, 1'b1, 32'hFFFF_FFA5, "R2 low byte", "R7 no event");
    step(1, 1'b0, 1'b0, 32'hFFFF_FFFF, "R2 hold", "R5 event");

    // R6: rise of enable clears, overriding a write and an increment
    step(7, 1'b1, 1'b1, 32'h0000_0033, "R6 clear", "R6 event");
    step(3, 1'b1, 1'b0, 32'h0, "R3 after clear", "R4 event");

    // R3/R4: every start value against every retired value, enable high
    for (int v = 0; v < 256; v++) begin
      for (int r = 0; r < 8; r++) begin
        step(0, 1'b1, 1'b1, 32'(v), "R7 preload", "R7 no event");
        step(r, 1'b1, 1'b0, 32'h0, "R3 add", "R4 carry");
      end
    end

    // R4: pulse lasts one cycle across back-to-back large adds
    step(0, 1'b1, 1'b1, 32'hFE, "R7 preload", "R7 no event");
    step(7, 1'b1, 1'b0, 32'h0, "R4 wrap to 0x04", "R4 pulse");
    step(7, 1'b1, 1'b0, 32'h0, "R3 next add", "R4 single cycle");

    // R7: write beats increment at 0xFF, no event
    step(0, 1'b1, 1'b1, 32'hFF, "R7 preload", "R7 no event");
    step(7, 1'b1, 1'b1, 32'h10, "R7 write wins", "R7 no event");

    // R5: enable low, wraps silently
    for (int v = 200; v < 256; v++) begin
      step(0, 1'b0, 1'b1, 32'(v), "R7 preload", "R7 no event");
      step(7, 1'b0, 1'b0, 32'h0, "R5 counts", "R5 gated");
    end

    // R6: rise again after a low period
    step(0, 1'b0, 1'b1, 32'h80, "R7 preload", "R7 no event");
    step(2, 1'b1, 1'b0, 32'h0, "R6 clear", "R6 event");
    step(6, 1'b1, 1'b0, 32'h0, "R3 after clear", "R4 event");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule